// File: doc/BRIEF.md
# Asynchronous serial transmitter with programmable character framing

This block turns parallel bytes into an asynchronous serial stream. A byte is handed over with a valid/ready handshake. The transmitter then drives one frame on its serial output. The frame is a low start bit, then 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period. The serial line rests high between frames.

A 5-bit line-control input sets the frame format. It selects the character length, the parity mode and the stop length. The stop length depends on both the stop select and the character length, so a 5-bit character can end with a stop period of one and a half bits. Bit timing comes from a one-cycle tick input that runs at sixteen times the bit rate, and every bit lasts a fixed number of ticks.

The line-control value is captured at the moment a byte is accepted. Changing the input while a frame is in flight therefore affects only later frames. A separate output reports when the shifter has nothing to send.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `in_ready` and `idle` are 1 and `txd` is 1.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` and `idle` stay 0 until the frame's last stop tick has been counted. While the block is busy, `in_valid` and `in_data` have no effect on the frame being sent.
- R3: A frame begins with `txd` low for 16 ticks. Each data bit then lasts 16 ticks, and the data bits go out least significant bit first.
- R4: `line_ctl[1:0]` selects the number of data bits sent: 00 sends 5, 01 sends 6, 10 sends 7 and 11 sends 8.
- R5: When `line_ctl[3]` is 1, one parity bit lasting 16 ticks follows the data bits. `line_ctl[4]`=1 gives even parity and 0 gives odd parity, counted over the data bits that are sent. When `line_ctl[3]` is 0, no parity bit is sent.
- R6: When `line_ctl[2]` is 0, the stop period is high for 16 ticks, whatever the character length.
- R7: When `line_ctl[2]` is 1 and the character length is 5, the stop period is high for 24 ticks.
- R8: When `line_ctl[2]` is 1 and the character length is 6, 7 or 8, the stop period is high for 32 ticks.
- R9: `line_ctl` is sampled on the accepting edge. Changes to it during a frame do not alter that frame.
- R10: While the block is busy, `txd` changes only after a clock edge on which `tick16` was 1. The frame ends only on such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| line_ctl | input | 5 | Frame format: [1:0] length, [2] stop select, [3] parity enable, [4] even parity |
| in_valid | input | 1 | Byte offered for transmission |
| in_data | input | 8 | Byte to send; bits above the selected length are ignored |
| in_ready | output | 1 | Block can accept a byte this cycle |
| txd | output | 1 | Serial output, high when idle |
| idle | output | 1 | Shifter has nothing in flight |

## Verification
The assertions assume that `tick16` is a synchronous single-cycle strobe that is never held high for long stretches. They also assume that the handshake inputs change only between clock edges. The bench pulses the tick once every three cycles from a divider, so ticks never fall on consecutive edges. It drives `in_valid`, `in_data` and `line_ctl` shortly after a rising edge. It also scrambles `line_ctl` and raises a stray `in_valid` during frames, but only while the block reports busy.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int MAX_W = 8;
    localparam int MIN_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // field order matches line_ctl[4:0]
    typedef struct packed {
        logic       par_even;
        logic       par_en;
        logic       stop_sel;
        logic [1:0] wlen;
    } line_cfg_t;

    function automatic line_cfg_t to_cfg(input logic [4:0] raw);
        return line_cfg_t'(raw);
    endfunction

    // parity over the active character bits only
    function automatic logic frame_parity(input logic [MAX_W-1:0] data,
                                          input line_cfg_t cfg);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < MAX_W; i++) begin
            if (i < MIN_W + int'(cfg.wlen)) acc = acc ^ data[i];
        end
        return cfg.par_even ? acc : ~acc;
    endfunction

endpackage

// File: rtl/uft_frame_plan.sv
module uft_frame_plan #(
    parameter int OVS = 16,
    parameter int CW  = 6,
    parameter int BW  = 4
) (
    input  logic [1:0]    wlen,
    input  logic          stop_sel,
    output logic [BW-1:0] n_bits,
    output logic [CW-1:0] stop_ticks
);
    import uft_pkg::*;

    localparam int ONE_STOP  = OVS;
    localparam int HALF_STOP = OVS + OVS / 2;
    localparam int TWO_STOP  = 2 * OVS;

    always_comb begin
        n_bits = BW'(MIN_W) + BW'(wlen);
        if (!stop_sel) begin
            stop_ticks = CW'(ONE_STOP);
        end else if (wlen == 2'b00) begin
            stop_ticks = CW'(HALF_STOP);
        end else begin
            stop_ticks = CW'(TWO_STOP);
        end
    end

endmodule

// File: rtl/uft_tick_counter.sv
module uft_tick_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = tick && (cnt_q == limit - CW'(1));
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = last ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [4:0] line_ctl,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       txd,
    output logic       idle
);
    import uft_pkg::*;

    localparam int CW = $clog2(2 * OVS + 1);
    localparam int BW = $clog2(MAX_W + 1);

    typedef struct packed {
        tx_state_e        state;
        logic [MAX_W-1:0] shreg;
        logic [BW-1:0]    bitcnt;
        line_cfg_t        cfg;
        logic             par;
    } tx_regs_t;

    localparam tx_regs_t REGS_RST = '{
        state:  ST_IDLE,
        shreg:  '0,
        bitcnt: '0,
        cfg:    '0,
        par:    1'b0
    };

    tx_regs_t      r_d, r_q;
    logic [BW-1:0] n_bits;
    logic [CW-1:0] stop_ticks;
    logic [CW-1:0] limit;
    logic          cnt_clear;
    logic          bit_last;

    uft_frame_plan #(.OVS(OVS), .CW(CW), .BW(BW)) u_plan (
        .wlen       (r_q.cfg.wlen),
        .stop_sel   (r_q.cfg.stop_sel),
        .n_bits     (n_bits),
        .stop_ticks (stop_ticks)
    );

    uft_tick_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (tick16),
        .limit (limit),
        .last  (bit_last)
    );

    always_comb begin
        r_d       = r_q;
        cnt_clear = (r_q.state == ST_IDLE);
        limit     = (r_q.state == ST_STOP) ? stop_ticks : CW'(OVS);

        unique case (r_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.state  = ST_START;
                    r_d.shreg  = in_data;
                    r_d.bitcnt = '0;
                    r_d.cfg    = to_cfg(line_ctl);
                    r_d.par    = frame_parity(in_data, to_cfg(line_ctl));
                end
            end
            ST_START: begin
                if (bit_last) r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bit_last) begin
                    r_d.shreg  = r_q.shreg >> 1;
                    r_d.bitcnt = r_q.bitcnt + BW'(1);
                    if (r_q.bitcnt == n_bits - BW'(1)) begin
                        r_d.state = r_q.cfg.par_en ? ST_PARITY : ST_STOP;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_last) r_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (bit_last) r_d.state = ST_IDLE;
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        in_ready = (r_q.state == ST_IDLE);
        idle     = (r_q.state == ST_IDLE);
        unique case (r_q.state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = r_q.shreg[0];
            ST_PARITY: txd = r_q.par;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic idle
);

    // R1: an idle line is high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> txd);

    // R2, R3: acceptance starts a busy frame with the start bit
    a_r2_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !idle && !txd));

    // R10: without a tick the serial output holds while busy
    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !tick16) |=> ($stable(txd) && !in_ready));

    // R10: a frame only ends on a tick
    a_r10_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(tick16));

endmodule

bind uart_frame_tx uft_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16   (tick16),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .txd      (txd),
    .idle     (idle)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int TPB        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic [4:0] line_ctl = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, txd, idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [1:0] tick_div = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) tick_div <= (tick_div == 2'd2) ? 2'd0 : tick_div + 2'd1;
    assign tick16 = (tick_div == 2'd2);

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_ctl(line_ctl),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .txd(txd), .idle(idle)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int nbits(input logic [4:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int stop_len(input logic [4:0] c);
        if (!c[2]) return TPB;
        if (c[1:0] == 2'b00) return TPB + TPB / 2;
        return 2 * TPB;
    endfunction

    function automatic int frame_ticks(input logic [4:0] c);
        return TPB * (1 + nbits(c) + int'(c[3])) + stop_len(c);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [4:0] c);
        logic p = 1'b0;
        for (int i = 0; i < nbits(c); i++) p ^= d[i];
        return c[4] ? p : ~p;
    endfunction

    function automatic logic exp_bit(input int k, input logic [7:0] d, input logic [4:0] c);
        int idx = k / TPB;
        if (idx == 0) return 1'b0;
        if (idx <= nbits(c)) return d[idx-1];
        if (c[3] && idx == nbits(c) + 1) return par_of(d, c);
        return 1'b1;
    endfunction

    function automatic string req_of(input int k, input logic [4:0] c);
        int idx = k / TPB;
        if (idx == 0) return "R3 R9 start";
        if (idx <= nbits(c)) return "R3 R4 R9 data";
        if (c[3] && idx == nbits(c) + 1) return "R5 R9 parity";
        if (!c[2]) return "R6 R9 stop";
        if (c[1:0] == 2'b00) return "R7 R9 stop";
        return "R8 R9 stop";
    endfunction

    task automatic send(input logic [7:0] d, input logic [4:0] c, input logic stray);
        int k = 0;
        int n = 0;
        int total = frame_ticks(c);
        string sreq;
        @(negedge clk);
        chk(in_ready === 1'b1, "R2 ready before accept", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = d;
        line_ctl = c;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        line_ctl = 5'($urandom);
        in_data  = 8'($urandom);
        while (k < total) begin
            @(negedge clk);
            chk(txd === exp_bit(k, d, c), tick16 ? req_of(k, c) : "R10 hold",
                int'(txd), int'(exp_bit(k, d, c)));
            chk(in_ready === 1'b0 && idle === 1'b0, "R2 busy", int'(in_ready), 0);
            if (stray && n == 5) begin
                in_valid = 1'b1;
                in_data  = ~d;
            end
            if (n == 9) in_valid = 1'b0;
            if (tick16) k++;
            n++;
        end
        @(negedge clk);
        if (!c[2]) sreq = "R6 frame end";
        else if (c[1:0] == 2'b00) sreq = "R7 frame end";
        else sreq = "R8 frame end";
        chk(in_ready === 1'b1 && idle === 1'b1, sreq, int'(in_ready), 1);
        chk(txd === 1'b1, "R1 line idle after frame", int'(txd), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7319));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(idle === 1'b1, "R1 reset idle", int'(idle), 1);
        chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);

        // directed: every length and stop combination, with and without parity
        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 2; s++) begin
                send(8'hA5, {2'b00, 1'(s), 2'(w)}, 1'b0);
                send(8'h3C, {2'b11, 1'(s), 2'(w)}, 1'b1);
                send(8'hFF, {2'b01, 1'(s), 2'(w)}, 1'b0);
            end
        end
        send(8'h00, 5'b11000, 1'b0);
        send(8'h00, 5'b01011, 1'b1);

        // random frames
        for (int i = 0; i < 40; i++) begin
            send(8'($urandom), 5'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule